// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is a single output cell of a sum-of-products programmable logic device. A parameterised group of product terms from the AND array is OR-ed into one sum. The sum either passes straight through or is captured in a D flip-flop, and is then driven with the selected polarity. Two configuration bits give four modes: registered or combinational, each active-high or active-low.

The same cell carries the pin's output-enable term and two device-wide control terms that act on the flip-flop. A preset term forces the register to one on a clock edge. A clear term forces it to zero at once, without waiting for a clock. The clear term is also the power-up reset. A feedback line returns a value to the array. In registered mode that value is the register contents. In combinational mode it is the pin value, so a disabled output can serve as an extra input.

Top module: `pld_macrocell`

## Requirements
- R1: With cfg_registered=0 and cfg_active_high=1, out_val equals the OR of all bits of terms in the same cycle.
- R2: With cfg_registered=0 and cfg_active_high=0, out_val equals the inverse of the OR of terms.
- R3: With cfg_registered=1 and cfg_active_high=1, out_val equals the register, which on each rising clk edge loads the OR of terms when clr_term and preset_term are both 0.
- R4: With cfg_registered=1 and cfg_active_high=0, out_val equals the inverse of the register.
- R5: A rising clk edge with preset_term=1 and clr_term=0 sets the register to 1, whatever the value of terms.
- R6: While clr_term=1 the register is 0, and it becomes 0 without a clock edge. The clear wins over preset_term and over terms.
- R7: out_en always equals oe_term, in every mode.
- R8: fb equals the register when cfg_registered=1, and equals pin_in when cfg_registered=0.
- R9: The register keeps loading on every clock edge in combinational mode. A change to registered mode therefore shows the last captured sum at once, with no extra edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| clr_term | input | 1 | Global clear, asynchronous, active high; also the power-up reset |
| preset_term | input | 1 | Global preset, synchronous, active high |
| terms | input | NUM_TERMS | Product terms OR-ed into the cell's sum |
| oe_term | input | 1 | Output-enable product term |
| cfg_registered | input | 1 | 1 = registered output, 0 = combinational output |
| cfg_active_high | input | 1 | 1 = true polarity, 0 = inverted output |
| pin_in | input | 1 | Value observed on the pin |
| out_val | output | 1 | Value to drive on the pin |
| out_en | output | 1 | Pin drive enable |
| fb | output | 1 | Feedback line to the array |

## Verification
A wrong register value can only be seen at the ports in registered mode. It shows on out_val and fb in the cycle after the bad edge, so the bench reads both outputs after every edge and also reads them between edges while the clear is asserted. A stale register hidden by combinational mode shows up as soon as the mode bit flips to registered, with no clock. A polarity or select fault shows on out_val in the same cycle the inputs change.

// File: rtl/pld_macrocell_pkg.sv
package pld_macrocell_pkg;
   typedef enum logic [1:0] {
      MODE_COMB_HI = 2'b01,
      MODE_COMB_LO = 2'b00,
      MODE_REG_HI  = 2'b11,
      MODE_REG_LO  = 2'b10
   } mc_mode_e;

   function automatic mc_mode_e mc_decode(input logic registered, input logic active_high);
      return mc_mode_e'({registered, active_high});
   endfunction

   function automatic logic mc_is_registered(input mc_mode_e m);
      return m[1];
   endfunction

   function automatic logic mc_is_inverted(input mc_mode_e m);
      return ~m[0];
   endfunction
endpackage

// File: rtl/mc_sum_or.sv
module mc_sum_or #(
   parameter int NUM_TERMS = 8
) (
   input  logic [NUM_TERMS-1:0] terms,
   output logic                 sum
);
   generate
      if (NUM_TERMS < 1) begin : g_bad_width
         $error("mc_sum_or: NUM_TERMS must be at least 1");
      end else if (NUM_TERMS == 1) begin : g_single
         assign sum = terms[0];
      end else begin : g_tree
         localparam int HALF = NUM_TERMS / 2;
         logic lo_sum;
         logic hi_sum;
         mc_sum_or #(.NUM_TERMS(HALF)) u_lo (
            .terms(terms[HALF-1:0]),
            .sum  (lo_sum)
         );
         mc_sum_or #(.NUM_TERMS(NUM_TERMS-HALF)) u_hi (
            .terms(terms[NUM_TERMS-1:HALF]),
            .sum  (hi_sum)
         );
         assign sum = lo_sum | hi_sum;
      end
   endgenerate
endmodule

// File: rtl/mc_flop.sv
module mc_flop #(
   parameter logic CLEAR_LEVEL  = 1'b0,
   parameter logic PRESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic clr,
   input  logic preset,
   input  logic d,
   output logic q
);
   generate
      if (CLEAR_LEVEL == PRESET_LEVEL) begin : g_bad_levels
         $error("mc_flop: clear and preset levels must differ");
      end
   endgenerate

   always_ff @(posedge clk or posedge clr) begin
      if (clr)         q <= CLEAR_LEVEL;
      else if (preset) q <= PRESET_LEVEL;
      else             q <= d;
   end
endmodule

// File: rtl/mc_outsel.sv
module mc_outsel
   import pld_macrocell_pkg::*;
#(
   parameter bit FEEDBACK_FROM_PIN = 1'b1
) (
   input  mc_mode_e mode,
   input  logic     sum,
   input  logic     q,
   input  logic     oe,
   input  logic     pin_in,
   output logic     out_val,
   output logic     out_en,
   output logic     fb
);
   logic selected;

   always_comb begin
      selected = mc_is_registered(mode) ? q : sum;
      out_val  = selected ^ mc_is_inverted(mode);
      out_en   = oe;
   end

   generate
      if (FEEDBACK_FROM_PIN) begin : g_fb_pin
         assign fb = mc_is_registered(mode) ? q : pin_in;
      end else begin : g_fb_sel
         assign fb = selected;
      end
   endgenerate
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
   import pld_macrocell_pkg::*;
#(
   parameter int NUM_TERMS = 8
) (
   input  logic                 clk,
   input  logic                 clr_term,
   input  logic                 preset_term,
   input  logic [NUM_TERMS-1:0] terms,
   input  logic                 oe_term,
   input  logic                 cfg_registered,
   input  logic                 cfg_active_high,
   input  logic                 pin_in,
   output logic                 out_val,
   output logic                 out_en,
   output logic                 fb
);
   localparam int MAX_TERMS = 64;

   generate
      if (NUM_TERMS < 1 || NUM_TERMS > MAX_TERMS) begin : g_bad_terms
         $error("pld_macrocell: NUM_TERMS out of range");
      end
   endgenerate

   mc_mode_e mode;
   logic     sum_w;
   logic     q_w;

   assign mode = mc_decode(cfg_registered, cfg_active_high);

   mc_sum_or #(.NUM_TERMS(NUM_TERMS)) u_sum (
      .terms(terms),
      .sum  (sum_w)
   );

   mc_flop #(.CLEAR_LEVEL(1'b0), .PRESET_LEVEL(1'b1)) u_flop (
      .clk   (clk),
      .clr   (clr_term),
      .preset(preset_term),
      .d     (sum_w),
      .q     (q_w)
   );

   mc_outsel #(.FEEDBACK_FROM_PIN(1'b1)) u_out (
      .mode   (mode),
      .sum    (sum_w),
      .q      (q_w),
      .oe     (oe_term),
      .pin_in (pin_in),
      .out_val(out_val),
      .out_en (out_en),
      .fb     (fb)
   );
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
   parameter int NUM_TERMS = 8
) (
   input logic                 clk,
   input logic                 clr_term,
   input logic                 preset_term,
   input logic [NUM_TERMS-1:0] terms,
   input logic                 oe_term,
   input logic                 cfg_registered,
   input logic                 cfg_active_high,
   input logic                 pin_in,
   input logic                 out_val,
   input logic                 out_en,
   input logic                 fb,
   input logic                 q
);
   // R1: combinational true polarity follows the OR of terms
   a_r1_comb_hi: assert property (@(posedge clk) disable iff (clr_term)
      (!cfg_registered && cfg_active_high) |-> (out_val == (|terms)));

   // R3: register loads the sum on an ordinary edge
   a_r3_load: assert property (@(posedge clk) disable iff (clr_term)
      !preset_term |=> (q == $past(|terms)));

   // R5: preset forces a one on the next edge
   a_r5_preset: assert property (@(posedge clk) disable iff (clr_term)
      preset_term |=> q);

   // R6: clear holds the register low regardless of the other terms
   a_r6_clear: assert property (@(posedge clk)
      clr_term |-> !q);

   // R7: enable follows its term
   a_r7_enable: assert property (@(posedge clk) disable iff (clr_term)
      out_en == oe_term);

   // R8: feedback source depends on the mode
   a_r8_feedback: assert property (@(posedge clk) disable iff (clr_term)
      fb == (cfg_registered ? q : pin_in));
endmodule

bind pld_macrocell pld_macrocell_chk #(.NUM_TERMS(NUM_TERMS)) u_chk (
   .clk            (clk),
   .clr_term       (clr_term),
   .preset_term    (preset_term),
   .terms          (terms),
   .oe_term        (oe_term),
   .cfg_registered (cfg_registered),
   .cfg_active_high(cfg_active_high),
   .pin_in         (pin_in),
   .out_val        (out_val),
   .out_en         (out_en),
   .fb             (fb),
   .q              (q_w)
);

// File: tb/pld_macrocell_test.sv
`timescale 1ns/1ps
module pld_macrocell_test;
   localparam int NT = 8;

   logic          clk = 1'b0;
   logic          clr_term, preset_term, oe_term;
   logic          cfg_registered, cfg_active_high, pin_in;
   logic [NT-1:0] terms;
   logic          out_val, out_en, fb;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  model_q  = 1'b0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;

   pld_macrocell #(.NUM_TERMS(NT)) uut (
      .clk(clk), .clr_term(clr_term), .preset_term(preset_term), .terms(terms),
      .oe_term(oe_term), .cfg_registered(cfg_registered),
      .cfg_active_high(cfg_active_high), .pin_in(pin_in),
      .out_val(out_val), .out_en(out_en), .fb(fb)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference: outputs from model state and current inputs
   task automatic compare_all();
      bit s;
      bit sel;
      string mtag;
      s   = (terms != '0);
      sel = cfg_registered ? model_q : s;
      if (!cfg_registered) mtag = cfg_active_high ? "R1" : "R2";
      else                 mtag = cfg_active_high ? "R3" : "R4";
      check(mtag, out_val, cfg_active_high ? sel : !sel);
      check("R7", out_en, oe_term);
      check("R8", fb, cfg_registered ? model_q : pin_in);
   endtask

   // Drive at the falling edge, update the model at the rising edge, compare after it
   task automatic step();
      bit s;
      @(posedge clk);
      s = (terms != '0);
      if (clr_term)         model_q = 1'b0;
      else if (preset_term) model_q = 1'b1;
      else                  model_q = s;
      #2;
      compare_all();
      @(negedge clk);
   endtask

   initial begin : watchdog
      #1_000_000;
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      clr_term = 1'b1; preset_term = 1'b0; oe_term = 1'b0; terms = '0;
      cfg_registered = 1'b1; cfg_active_high = 1'b1; pin_in = 1'b0;
      #1;
      check("R6 reset", fb, 1'b0);
      check("R3 reset out", out_val, 1'b0);
      @(negedge clk);
      step();
      clr_term = 1'b0;

      // R3: registered load
      terms = 8'h10; oe_term = 1'b1; step();
      check("R3 load one", out_val, 1'b1);
      terms = '0; step();
      check("R3 load zero", out_val, 1'b0);

      // R5: preset with a zero sum
      preset_term = 1'b1; step();
      check("R5 preset", fb, 1'b1);
      preset_term = 1'b0;

      // R4: inverted registered
      cfg_active_high = 1'b0; terms = 8'h01; step();
      check("R4 inverted", out_val, 1'b0);

      // R6: async clear between edges, with preset also asserted
      #1;
      clr_term = 1'b1; preset_term = 1'b1;
      #1;
      model_q = 1'b0;
      check("R6 async", fb, 1'b0);
      check("R6 async out", out_val, 1'b1);
      step();
      check("R6 beats preset", fb, 1'b0);
      clr_term = 1'b0; preset_term = 1'b0;

      // R1 / R2 / R8: combinational modes
      cfg_registered = 1'b0; cfg_active_high = 1'b1; terms = 8'h80; pin_in = 1'b1;
      #1;
      check("R1 comb", out_val, 1'b1);
      check("R8 pin fb", fb, 1'b1);
      cfg_active_high = 1'b0;
      #1;
      check("R2 comb inv", out_val, 1'b0);

      // R9: register still loads in combinational mode
      cfg_active_high = 1'b1; terms = 8'h04; step();
      terms = '0;
      cfg_registered = 1'b1;
      #1;
      check("R9 captured", out_val, 1'b1);
      check("R9 fb", fb, 1'b1);
      @(negedge clk);

      // Random traffic against the model
      for (int i = 0; i < 400; i++) begin
         terms           = NT'($urandom) & NT'($urandom);
         oe_term         = 1'($urandom);
         cfg_registered  = 1'($urandom);
         cfg_active_high = 1'($urandom);
         pin_in          = 1'($urandom);
         preset_term     = ($urandom_range(0, 9) == 0);
         clr_term        = ($urandom_range(0, 15) == 0);
         #1;
         if (clr_term) model_q = 1'b0;
         compare_all();
         step();
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule